// File: doc/BRIEF.md
# Address-Wakeup Asynchronous Serial Receiver

This block receives asynchronous serial frames that carry one extra flag bit after the eight data bits. The flag tells an address (ID) frame apart from a data frame. Several stations can share one line. A station that is not being addressed sets its wait-for-ID control, and the receiver then drops every data frame without loading anything or disturbing the host. When an ID frame arrives, the receiver loads its byte, sets the full flag and drops the wait control on its own. Host software then reads the ID. If the ID names this station, the frames that follow arrive as normal traffic. If it does not, software sets the wait control again.

Bit timing comes from an external strobe at sixteen times the bit rate. The receiver confirms a start bit at mid-bit and samples every later bit at its centre. It flags a bad stop bit and a frame that arrives while the previous byte is still unread. The host side is a set of level and pulse signals: a set strobe for the wait control, clear strobes for the full flag and the error flags, and an interrupt enable.

Top module: `mpr_uart_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits with bit 0 first, one flag bit, then a high stop bit. An accepted frame's data bits appear on `rx_data` with the first data bit received in bit 0.
- R2: A low pulse on the idle line that ends before mid-bit (sample 8 of 16) does not start a frame: nothing is loaded and no flag changes.
- R3: While `wait_id` is 1, a frame whose flag bit is 0 is dropped. `rx_data` keeps its old value, `rx_full` stays 0, `rx_irq` stays 0 and `wait_id` stays 1.
- R4: While `wait_id` is 1, a frame whose flag bit is 1 loads `rx_data` and sets `rx_full`.
- R5: A pulse on `wake_set` sets `wait_id` to 1. Loading a frame whose flag bit is 1 clears `wait_id` to 0 in the same clock, and this takes priority over `wake_set`.
- R6: While `wait_id` is 0, every frame with a good stop bit is loaded, whatever its flag bit. This holds at any strobe spacing.
- R7: A frame whose stop bit is sampled as 0 sets `frame_err` and is not loaded.
- R8: A frame that would be loaded while `rx_full` is 1 sets `overrun` and leaves `rx_data` and `rx_full` unchanged. A `full_clr` in the same clock as the frame's completion frees the register first.
- R9: `last_mpb` shows the flag bit of the most recently loaded frame.
- R10: `rx_irq` is 1 exactly while `rx_full` is 1 and `irq_en` is 1.
- R11: A `wake_set` pulse that arrives while a frame is being received takes effect for that frame's accept decision at the stop bit.
- R12: `full_clr` clears `rx_full`. `err_clr` clears both `frame_err` and `overrun`. A new error event in the same clock as the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial receive line, high when idle |
| os_tick | input | 1 | Strobe at 16x the bit rate, one clock wide |
| irq_en | input | 1 | Receive interrupt enable |
| wake_set | input | 1 | Pulse: set the wait-for-ID control |
| full_clr | input | 1 | Pulse: clear the full flag |
| err_clr | input | 1 | Pulse: clear the framing and overrun flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive register holds an unread byte |
| wait_id | output | 1 | Wait-for-ID control state |
| last_mpb | output | 1 | Flag bit of the last loaded frame |
| frame_err | output | 1 | Stop bit was sampled low |
| overrun | output | 1 | Frame completed while the register was full |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The accept decision falls on the stop-bit centre sample. That sample comes two synchronizer clocks plus about eight strobes after the stop bit begins on the line, and all register results change on the next clock edge. The bench therefore samples each result only after the whole stop bit and a further two idle bit times have passed, one time unit after a rising edge, so every result has settled whatever the strobe phase. Host strobes change only the registers they target, one clock after they are pulsed. They are checked after a further full clock.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2
  } rx_state_e;

  // strobe index at which the start bit is re-checked (centre of bit)
  function automatic int unsigned mid_phase(input int unsigned osr);
    return osr / 2 - 1;
  endfunction

  // number of sampled bits after the start bit: data + flag + stop
  function automatic int unsigned tail_bits(input int unsigned data_w);
    return data_w + 2;
  endfunction

  // a completed frame is a candidate for loading when its stop bit is good
  // and the wait-for-ID filter lets it through
  function automatic logic frame_eligible(input logic stop_ok,
                                          input logic waiting,
                                          input logic flag);
    return stop_ok && (!waiting || flag);
  endfunction

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mpr_frame_rx.sv
module mpr_frame_rx
  import mpr_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic              tick,
  output logic              done,
  output logic              stop_ok,
  output logic [DATA_W-1:0] frame_byte,
  output logic              frame_flag
);
  localparam int PH_W   = $clog2(OSR);
  localparam int NBITS  = tail_bits(DATA_W);
  localparam int BIT_W  = $clog2(NBITS + 1);
  localparam int MID    = mid_phase(OSR);
  localparam int FLAG_I = DATA_W;
  localparam int LAST_I = NBITS - 1;

  rx_state_e          state_q;
  logic [PH_W-1:0]    ph_q;
  logic [BIT_W-1:0]   bitn_q;
  logic [DATA_W-1:0]  sr_q;
  logic               flag_q;

  // named events for the checks below
  logic ph_full, ph_mid, bit_sample, start_ok, start_fail;

  assign ph_full    = (ph_q == PH_W'(OSR - 1));
  assign ph_mid     = (ph_q == PH_W'(MID));
  assign bit_sample = tick && (state_q == ST_SHIFT) && ph_full;
  assign start_ok   = tick && (state_q == ST_START) && ph_mid && !rx_s;
  assign start_fail = tick && (state_q == ST_START) && ph_mid && rx_s;
  assign done       = bit_sample && (bitn_q == BIT_W'(LAST_I));
  assign stop_ok    = rx_s;
  assign frame_byte = sr_q;
  assign frame_flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bitn_q  <= '0;
      sr_q    <= '0;
      flag_q  <= 1'b0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rx_s) begin
            state_q <= ST_START;
            ph_q    <= '0;
          end
        end
        ST_START: begin
          if (ph_mid) begin
            ph_q   <= '0;
            bitn_q <= '0;
            state_q <= rx_s ? ST_IDLE : ST_SHIFT;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ph_full) begin
            ph_q   <= '0;
            bitn_q <= bitn_q + 1'b1;
            if (bitn_q < BIT_W'(FLAG_I))
              sr_q <= {rx_s, sr_q[DATA_W-1:1]};
            else if (bitn_q == BIT_W'(FLAG_I))
              flag_q <= rx_s;
            if (bitn_q == BIT_W'(LAST_I))
              state_q <= ST_IDLE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a start bit that is high again at mid-bit returns the receiver to idle
  a_r2_glitch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |=> (state_q == ST_IDLE));

  // R1: the bit index never runs past the stop bit while shifting
  a_r1_bit_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (bitn_q <= BIT_W'(LAST_I)));

  // R1: start confirmation, start rejection and frame completion never coincide
  a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ok, start_fail, done}));
endmodule

// File: rtl/mpr_host_regs.sv
module mpr_host_regs
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              stop_ok,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              frame_flag,
  input  logic              irq_en,
  input  logic              wake_set,
  input  logic              full_clr,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              wait_id,
  output logic              last_mpb,
  output logic              frame_err,
  output logic              overrun,
  output logic              rx_irq
);
  logic [DATA_W-1:0] data_q;
  logic full_q, wait_q, mpb_q, ferr_q, ovr_q;

  // named events
  logic wait_eff, full_eff, elig, load_ev, ovr_ev, ferr_ev;

  assign wait_eff = wait_q | wake_set;          // R11: late set still counts
  assign full_eff = full_q & ~full_clr;         // R8: clear frees register first
  assign elig     = done && frame_eligible(stop_ok, wait_eff, frame_flag);
  assign load_ev  = elig && !full_eff;
  assign ovr_ev   = elig && full_eff;
  assign ferr_ev  = done && !stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      wait_q <= 1'b0;
      mpb_q  <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load_ev) begin
        data_q <= frame_byte;
        mpb_q  <= frame_flag;
      end

      if (load_ev)       full_q <= 1'b1;
      else if (full_clr) full_q <= 1'b0;

      if (load_ev && frame_flag) wait_q <= 1'b0;
      else if (wake_set)         wait_q <= 1'b1;

      if (ferr_ev)      ferr_q <= 1'b1;
      else if (err_clr) ferr_q <= 1'b0;

      if (ovr_ev)       ovr_q <= 1'b1;
      else if (err_clr) ovr_q <= 1'b0;
    end
  end

  assign rx_data   = data_q;
  assign rx_full   = full_q;
  assign wait_id   = wait_q;
  assign last_mpb  = mpb_q;
  assign frame_err = ferr_q;
  assign overrun   = ovr_q;
  assign rx_irq    = full_q & irq_en;

  // R3: a skipped data frame leaves the register untouched and no new full
  a_r3_skip_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_ok && wait_eff && !frame_flag) |=> ($stable(data_q) && !$rose(full_q)));

  // R4: an ID frame into an empty register loads it
  a_r4_id_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_ok && frame_flag && !full_eff) |=> (full_q && data_q == $past(frame_byte)));

  // R5: loading an ID frame drops the wait control
  a_r5_id_clears_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && frame_flag) |=> !wait_q);

  // R7: a bad stop bit flags an error and loads nothing
  a_r7_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_ev |=> (frame_err && $stable(data_q)));

  // R8: a frame arriving into a full register is not written
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> (overrun && $stable(data_q) && full_q));

  // R10: the request never stands without an unread byte
  a_r10_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (full_q && irq_en));
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx
  import mpr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              irq_en,
  input  logic              wake_set,
  input  logic              full_clr,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              wait_id,
  output logic              last_mpb,
  output logic              frame_err,
  output logic              overrun,
  output logic              rx_irq
);
  logic              rx_s;
  logic              done;
  logic              stop_ok;
  logic [DATA_W-1:0] frame_byte;
  logic              frame_flag;

  mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_line),
    .d_out (rx_s)
  );

  mpr_frame_rx #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_s       (rx_s),
    .tick       (os_tick),
    .done       (done),
    .stop_ok    (stop_ok),
    .frame_byte (frame_byte),
    .frame_flag (frame_flag)
  );

  mpr_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .stop_ok    (stop_ok),
    .frame_byte (frame_byte),
    .frame_flag (frame_flag),
    .irq_en     (irq_en),
    .wake_set   (wake_set),
    .full_clr   (full_clr),
    .err_clr    (err_clr),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .wait_id    (wait_id),
    .last_mpb   (last_mpb),
    .frame_err  (frame_err),
    .overrun    (overrun),
    .rx_irq     (rx_irq)
  );
endmodule

// File: tb/mpr_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mpr_uart_rx_tb_top;
  localparam int OSR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic os_tick = 1'b0;
  logic irq_en = 1'b0;
  logic wake_set = 1'b0;
  logic full_clr = 1'b0;
  logic err_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, wait_id, last_mpb, frame_err, overrun, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  int div = 1;
  int tcnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // strobe: one clock in every `div`
  always @(posedge clk) begin
    if (tcnt + 1 >= div) begin tcnt <= 0; os_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; os_tick <= (div == 1); end
  end

  mpr_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .irq_en(irq_en), .wake_set(wake_set), .full_clr(full_clr), .err_clr(err_clr),
    .rx_data(rx_data), .rx_full(rx_full), .wait_id(wait_id), .last_mpb(last_mpb),
    .frame_err(frame_err), .overrun(overrun), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    @(posedge clk); #1 s = 1'b1;
    @(posedge clk); #1 s = 1'b0;
    clocks(1);
  endtask

  // wake_bit < 0: no mid-frame wake pulse; otherwise pulse at that bit index
  task automatic send(input logic [7:0] b, input logic flag, input logic stop,
                      input int wake_bit);
    logic [10:0] bits;
    int bt;
    bt = OSR * div;
    bits = {stop, flag, b, 1'b0};
    @(posedge clk); #1;
    for (int k = 0; k < 11; k++) begin
      rx_line = bits[k];
      if (k == wake_bit) begin
        @(posedge clk); #1 wake_set = 1'b1;
        @(posedge clk); #1 wake_set = 1'b0;
        clocks(bt - 2);
      end else begin
        clocks(bt);
      end
    end
    rx_line = 1'b1;
    clocks(2 * bt);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] prev;
    logic exp_flag;
    clocks(4);
    rst_n = 1'b1;
    clocks(2);
    // reset state
    chk("R12 reset full", rx_full, 0);
    chk("R5 reset wait", wait_id, 0);
    chk("R12 reset errs", {frame_err, overrun}, 0);
    chk("R10 reset irq", rx_irq, 0);
    chk("R1 reset data", rx_data, 0);

    // normal reception, interrupt on
    irq_en = 1'b1;
    send(8'hA5, 1'b0, 1'b1, -1);
    chk("R1 data A5", rx_data, 8'hA5);
    chk("R6 flag0 accepted", rx_full, 1);
    chk("R9 last flag 0", last_mpb, 0);
    chk("R10 irq high", rx_irq, 1);
    irq_en = 1'b0; clocks(1);
    chk("R10 irq masked", rx_irq, 0);
    irq_en = 1'b1;

    // overrun
    send(8'h3C, 1'b1, 1'b1, -1);
    chk("R8 overrun set", overrun, 1);
    chk("R8 data kept", rx_data, 8'hA5);
    chk("R8 full kept", rx_full, 1);
    chk("R9 last flag unchanged", last_mpb, 0);
    pulse(full_clr);
    chk("R12 full cleared", rx_full, 0);
    chk("R10 irq dropped", rx_irq, 0);
    pulse(err_clr);
    chk("R12 overrun cleared", overrun, 0);

    // framing error
    send(8'h5A, 1'b1, 1'b0, -1);
    chk("R7 frame_err", frame_err, 1);
    chk("R7 not loaded", rx_full, 0);
    chk("R7 data kept", rx_data, 8'hA5);
    pulse(err_clr);
    chk("R12 frame_err cleared", frame_err, 0);

    // short glitch on idle line (3 strobes)
    rx_line = 1'b0; clocks(3 * div);
    rx_line = 1'b1; clocks(3 * OSR * div);
    chk("R2 glitch no load", rx_full, 0);
    chk("R2 glitch no error", {frame_err, overrun}, 0);
    send(8'h81, 1'b1, 1'b1, -1);
    chk("R2 next frame clean", rx_data, 8'h81);
    chk("R9 last flag 1", last_mpb, 1);
    pulse(full_clr);

    // wake_set during a data frame applies at its stop decision
    send(8'h77, 1'b0, 1'b1, 4);
    chk("R11 late wake dropped frame", rx_full, 0);
    chk("R11 wait set", wait_id, 1);
    chk("R11 data kept", rx_data, 8'h81);

    // exhaustive byte sweep with the filter on
    prev = 8'h81;
    for (int b = 0; b < 256; b++) begin
      exp_flag = (b % 3 == 0);
      pulse(wake_set);
      chk("R5 wake sets wait", wait_id, 1);
      send(b[7:0], exp_flag, 1'b1, -1);
      if (exp_flag) begin
        chk("R4 id loaded", rx_data, b);
        chk("R4 full set", rx_full, 1);
        chk("R5 wait cleared", wait_id, 0);
        chk("R9 last flag", last_mpb, 1);
        prev = b[7:0];
      end else begin
        chk("R3 data kept", rx_data, prev);
        chk("R3 no full", rx_full, 0);
        chk("R3 no irq", rx_irq, 0);
        chk("R3 still waiting", wait_id, 1);
      end
      if (rx_full) pulse(full_clr);
    end

    // normal mode at a wider strobe spacing, both flag values
    div = 3; clocks(8);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      send(v, i[0], 1'b1, -1);
      chk("R6 normal data", rx_data, v);
      chk("R6 normal full", rx_full, 1);
      chk("R9 flag track", last_mpb, i[0]);
      pulse(full_clr);
    end
    chk("R6 no errors", {frame_err, overrun}, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule